// File: doc/BRIEF.md
# GPIO Trigger Detector

This block watches a group of general-purpose input pins and records interrupt events per pin. Every pin can look for a rising edge, a falling edge, both edges, or an active-high or active-low level. Events set sticky pending bits, and software clears them by writing ones. Pin inputs are asynchronous. They pass through a synchronizer before any edge or level is evaluated.

The pending bits are split into groups of sixteen pins, and each group drives its own interrupt line. A pin only reaches that line when its interrupt enable bit is set. A separate wakeup request output is asserted by any pending pin whose wakeup enable bit is set, whatever the interrupt enables hold.

A word-wide register port gives access to six per-pin registers, spaced 16 bytes apart. A typical interrupt handler reads the pending register, services the pins it finds, and writes the same value back to clear them.

Top module: `gtd_top`

## Requirements
- R1: After reset every register reads 0, both interrupt lines are low and the wakeup output is low.
- R2: Register index is `bus_addr_i[6:4]` and `bus_addr_i[3:0]` must be 0 for an access to hit. Index 0 is interrupt enable, 1 is pending, 2 is both-edge select, 3 is level select, 4 is polarity and 5 is wakeup enable. Index 0 and indices 2 to 5 read back what was written. Indices 6 and 7, and any access that misses, read 0 and write nothing.
- R3: A pin with level select 0 and both-edge select 0 sets its pending bit on a rising edge when polarity is 1, and on a falling edge when polarity is 0. A pin change that is set up before rising clock edge n shows in the pending bit after edge n+2.
- R4: A pin with level select 0 and both-edge select 1 sets its pending bit on either edge, whatever its polarity bit holds.
- R5: A pin with level select 1 sets its pending bit in every cycle that its synchronized input equals its polarity bit (1 means active high, 0 means active low). A clear does not take effect while the level stays active, and the bit stays set after the level goes away.
- R6: A write to the pending register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R7: If an event on a pin and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: Pending bits are recorded whatever the interrupt enable bits hold.
- R9: `irq_o[g]` is high exactly when some pin in group g has both its pending bit and its interrupt enable bit set. Group g covers pins 16g to 16g+15.
- R10: `wake_o` is high exactly when some pin has both its pending bit and its wakeup enable bit set. This does not depend on the interrupt enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin levels |
| bus_en_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 7 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data, one bit per pin |
| bus_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 2 | Interrupt line for each 16-pin group |
| wake_o | output | 1 | Wakeup request |

## Verification
The hardest case to reach is an edge event on a pin that lands in the same clock cycle as a clear of that pin's pending bit. The pin is first toggled once so that its bit is set. It is then toggled again, and the bench counts the synchronizer stages so that the clear is held on the bus across exactly the edge where the new event is recorded. A read afterwards must still see the bit set. The level-mode case, where a clear has no effect while the level is active, is reached by holding the pin active across the clear and then releasing it.

// File: rtl/gtd_pkg.sv
package gtd_pkg;
    localparam int unsigned GTD_PINS_DFLT  = 32;
    localparam int unsigned GTD_GROUP_DFLT = 16;
    localparam int unsigned GTD_SYNC_DFLT  = 2;
    localparam int unsigned GTD_STRIDE_LG  = 4;

    typedef enum logic [2:0] {
        RI_IEN  = 3'd0,
        RI_PEND = 3'd1,
        RI_CHG  = 3'd2,
        RI_LVL  = 3'd3,
        RI_POL  = 3'd4,
        RI_WAKE = 3'd5
    } reg_idx_e;
endpackage

// File: rtl/gtd_sync.sv
module gtd_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    // Stages 0..STAGES-1 synchronize the pins; stage STAGES holds the previous synchronized value.
    logic [W-1:0] stg_q [STAGES+1];

    for (genvar s = 0; s <= STAGES; s++) begin : g_stage
        logic [W-1:0] src;
        if (s == 0) begin : g_first
            assign src = d_i;
        end else begin : g_next
            assign src = stg_q[s-1];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[s] <= '0;
            else         stg_q[s] <= src;
        end
    end

    assign cur_o  = stg_q[STAGES-1];
    assign prev_o = stg_q[STAGES];
endmodule

// File: rtl/gtd_detect.sv
module gtd_detect #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] chg_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] evt_o
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic rise, fall;
        assign rise = cur_i[p] & ~prev_i[p];
        assign fall = ~cur_i[p] & prev_i[p];
        always_comb begin
            if (lvl_i[p])      evt_o[p] = ~(cur_i[p] ^ pol_i[p]);
            else if (chg_i[p]) evt_o[p] = rise | fall;
            else if (pol_i[p]) evt_o[p] = rise;
            else               evt_o[p] = fall;
        end
    end
endmodule

// File: rtl/gtd_irq_merge.sv
module gtd_irq_merge #(
    parameter int unsigned W     = 32,
    parameter int unsigned GROUP = 16,
    localparam int unsigned NGRP = W / GROUP
) (
    input  logic [W-1:0]    pend_i,
    input  logic [W-1:0]    ien_i,
    input  logic [W-1:0]    wen_i,
    output logic [NGRP-1:0] irq_o,
    output logic            wake_o
);
    logic [W-1:0] live;
    assign live = pend_i & ien_i;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign irq_o[g] = |live[g*GROUP +: GROUP];
    end

    assign wake_o = |(pend_i & wen_i);
endmodule

// File: rtl/gtd_top.sv
module gtd_top
    import gtd_pkg::*;
#(
    parameter int unsigned NPINS  = GTD_PINS_DFLT,
    parameter int unsigned GROUP  = GTD_GROUP_DFLT,
    parameter int unsigned SYNC_N = GTD_SYNC_DFLT,
    parameter int unsigned ADDR_W = 7,
    localparam int unsigned NGRP  = NPINS / GROUP,
    localparam int unsigned IDX_W = ADDR_W - GTD_STRIDE_LG
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NPINS-1:0]  pin_i,
    input  logic              bus_en_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [NPINS-1:0]  bus_wdata_i,
    output logic [NPINS-1:0]  bus_rdata_o,
    output logic [NGRP-1:0]   irq_o,
    output logic              wake_o
);
    typedef struct packed {
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] pend;
        logic [NPINS-1:0] chg;
        logic [NPINS-1:0] lvl;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] wen;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [NPINS-1:0] cur, prev, evt, clr;
    logic [NPINS-1:0] pend_q, ien_q, wen_q;
    logic [IDX_W-1:0] idx;
    logic             hit, wr, rd;

    assign idx = bus_addr_i[ADDR_W-1:GTD_STRIDE_LG];
    assign hit = bus_en_i && (bus_addr_i[GTD_STRIDE_LG-1:0] == '0);
    assign wr  = hit && bus_wr_i;
    assign rd  = hit && !bus_wr_i;

    gtd_sync #(.W(NPINS), .STAGES(SYNC_N)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pin_i),
        .cur_o  (cur),
        .prev_o (prev)
    );

    gtd_detect #(.W(NPINS)) u_det (
        .cur_i  (cur),
        .prev_i (prev),
        .lvl_i  (regs_q.lvl),
        .chg_i  (regs_q.chg),
        .pol_i  (regs_q.pol),
        .evt_o  (evt)
    );

    always_comb begin
        regs_d = regs_q;
        clr    = '0;
        if (wr) begin
            case (idx)
                IDX_W'(RI_IEN):  regs_d.ien = bus_wdata_i;
                IDX_W'(RI_PEND): clr        = bus_wdata_i;
                IDX_W'(RI_CHG):  regs_d.chg = bus_wdata_i;
                IDX_W'(RI_LVL):  regs_d.lvl = bus_wdata_i;
                IDX_W'(RI_POL):  regs_d.pol = bus_wdata_i;
                IDX_W'(RI_WAKE): regs_d.wen = bus_wdata_i;
                default: ;
            endcase
        end
        // A fresh event outranks a clear of the same bit.
        regs_d.pend = (regs_q.pend & ~clr) | evt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (rd) begin
            case (idx)
                IDX_W'(RI_IEN):  bus_rdata_o = regs_q.ien;
                IDX_W'(RI_PEND): bus_rdata_o = regs_q.pend;
                IDX_W'(RI_CHG):  bus_rdata_o = regs_q.chg;
                IDX_W'(RI_LVL):  bus_rdata_o = regs_q.lvl;
                IDX_W'(RI_POL):  bus_rdata_o = regs_q.pol;
                IDX_W'(RI_WAKE): bus_rdata_o = regs_q.wen;
                default:         bus_rdata_o = '0;
            endcase
        end
    end

    assign pend_q = regs_q.pend;
    assign ien_q  = regs_q.ien;
    assign wen_q  = regs_q.wen;

    gtd_irq_merge #(.W(NPINS), .GROUP(GROUP)) u_irq (
        .pend_i (pend_q),
        .ien_i  (ien_q),
        .wen_i  (wen_q),
        .irq_o  (irq_o),
        .wake_o (wake_o)
    );
endmodule

// File: rtl/gtd_checks.sv
module gtd_checks #(
    parameter int unsigned NPINS = 32,
    parameter int unsigned NGRP  = 2
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_i,
    input logic [NPINS-1:0] ien_i,
    input logic [NPINS-1:0] wen_i,
    input logic [NPINS-1:0] pend_i,
    input logic [NPINS-1:0] evt_i,
    input logic [NPINS-1:0] clr_i,
    input logic [NGRP-1:0]  irq_i,
    input logic             wake_i
);
    // R3: a pending bit can only rise after the detector reported an event for that pin.
    p_set_by_event_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((pend_i & ~$past(pend_i) & ~$past(evt_i)) == '0));

    // R6: a clear of a bit without a concurrent event empties that bit.
    p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((clr_i & ~evt_i) != '0) |=> ((pend_i & $past(clr_i & ~evt_i)) == '0));

    // R7: every reported event is held in pending, even with a clear of the same bit.
    p_event_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((pend_i & $past(evt_i)) == $past(evt_i)));

    // R9: with all interrupt enables clear, no interrupt line is raised.
    p_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ien_i == '0) |-> (irq_i == '0));

    // R10: with all wakeup enables clear, no wakeup request is raised.
    p_wake_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wen_i == '0) |-> !wake_i);

    // R2: the enable registers change only on a bus write.
    p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> ($stable(ien_i) && $stable(wen_i)));
endmodule

bind gtd_top gtd_checks #(.NPINS(NPINS), .NGRP(NGRP)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .ien_i  (ien_q),
    .wen_i  (wen_q),
    .pend_i (pend_q),
    .evt_i  (evt),
    .clr_i  (clr),
    .irq_i  (irq_o),
    .wake_i (wake_o)
);

// File: tb/sim_gtd_top.sv
module sim_gtd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins = '0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;
    logic        wake;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gtd_top u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .pin_i       (pins),
        .bus_en_i    (bus_en),
        .bus_wr_i    (bus_wr),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .irq_o       (irq),
        .wake_o      (wake)
    );

    // Behavioural reference: sync pipeline and register state, updated per clock.
    logic [31:0] m_ien, m_pend, m_chg, m_lvl, m_pol, m_wen;
    logic [31:0] m_s1, m_s2, m_prev, m_ev, m_clr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ien = 0; m_pend = 0; m_chg = 0; m_lvl = 0; m_pol = 0; m_wen = 0;
            m_s1 = 0; m_s2 = 0; m_prev = 0;
        end else begin
            for (int i = 0; i < 32; i++) begin
                if (m_lvl[i])      m_ev[i] = (m_s2[i] == m_pol[i]);
                else if (m_chg[i]) m_ev[i] = (m_s2[i] != m_prev[i]);
                else if (m_pol[i]) m_ev[i] = (m_s2[i] && !m_prev[i]);
                else               m_ev[i] = (!m_s2[i] && m_prev[i]);
            end
            m_clr = 0;
            if (bus_en && bus_wr && bus_addr[3:0] == 0) begin
                case (int'(bus_addr[6:4]))
                    0: m_ien = bus_wdata;
                    1: m_clr = bus_wdata;
                    2: m_chg = bus_wdata;
                    3: m_lvl = bus_wdata;
                    4: m_pol = bus_wdata;
                    5: m_wen = bus_wdata;
                    default: ;
                endcase
            end
            m_pend = (m_pend & ~m_clr) | m_ev;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pins;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R9 irq vs model", {30'b0, irq},
                {30'b0, |(m_pend[31:16] & m_ien[31:16]), |(m_pend[15:0] & m_ien[15:0])});
            chk("R10 wake vs model", {31'b0, wake}, {31'b0, |(m_pend & m_wen)});
        end
    end

    // Called right after a falling edge.
    task automatic rd(input int idx, input logic [31:0] exp, input string tag);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 7'(idx * 16);
        #1;
        chk(tag, bus_rdata, exp);
        bus_en = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 7'(idx * 16); bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 actual=hang expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        for (int i = 0; i < 8; i++) rd(i, 32'h0, "R1 reset register value");
        chk("R1 reset irq", {30'b0, irq}, 32'h0);
        chk("R1 reset wake", {31'b0, wake}, 32'h0);

        // R2 map and read-back
        wr(0, 32'h1234_5678); rd(0, 32'h1234_5678, "R2 ien readback");
        wr(5, 32'hFFFF_0000); rd(5, 32'hFFFF_0000, "R2 wake readback");
        wr(2, 32'h0000_00F0); rd(2, 32'h0000_00F0, "R2 chg readback");
        wr(4, 32'h0000_000F); rd(4, 32'h0000_000F, "R2 pol readback");
        wr(6, 32'hDEAD_BEEF); rd(6, 32'h0, "R2 unused index reads 0");
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 7'h04; bus_wdata = 32'h0;
        @(negedge clk); bus_en = 1'b0; bus_wr = 1'b0;
        rd(0, 32'h1234_5678, "R2 misaligned write ignored");
        do_reset();

        // R3 rising/falling with latency
        wr(4, 32'h0000_0001);
        pins[1:0] = 2'b11;
        wait_n(2); rd(1, 32'h0, "R3 not yet after edge n+1");
        wait_n(1); rd(1, 32'h1, "R3 rising pol1 after edge n+2");
        wr(1, 32'h1); rd(1, 32'h0, "R3 cleared");
        pins[1:0] = 2'b00;
        wait_n(3); rd(1, 32'h2, "R3 falling pol0");
        wr(1, 32'h2);

        // R4 both edges
        wr(2, 32'h0000_0004);
        pins[2] = 1'b1; wait_n(3); rd(1, 32'h4, "R4 rise with chg");
        wr(1, 32'h4); rd(1, 32'h0, "R4 cleared");
        pins[2] = 1'b0; wait_n(3); rd(1, 32'h4, "R4 fall with chg");
        wr(1, 32'h4);

        // R5 level mode
        wr(4, 32'h0001_0001);
        wr(3, 32'h0001_0000);
        rd(1, 32'h0, "R5 inactive level no event");
        pins[16] = 1'b1; wait_n(3); rd(1, 32'h0001_0000, "R5 active high sets");
        wr(1, 32'h0001_0000); rd(1, 32'h0001_0000, "R5 clear blocked while active");
        pins[16] = 1'b0; wait_n(3); rd(1, 32'h0001_0000, "R5 sticky after release");
        wr(1, 32'h0001_0000); rd(1, 32'h0, "R5 clear after release");
        wr(3, 32'h0);

        // R6 write-one-to-clear
        pins[0] = 1'b1; wait_n(3); rd(1, 32'h1, "R6 setup");
        wr(1, 32'hFFFF_FFFE); rd(1, 32'h1, "R6 zero bit unchanged");
        wr(1, 32'h1); rd(1, 32'h0, "R6 one bit cleared");

        // R7 event and clear in the same cycle
        pins[2] = 1'b1; wait_n(3); rd(1, 32'h4, "R7 setup");
        pins[2] = 1'b0;
        wait_n(2);
        wr(1, 32'h4);
        rd(1, 32'h4, "R7 event wins over clear");
        wr(1, 32'h4); rd(1, 32'h0, "R7 plain clear");

        // R8 / R9 enable gating
        wr(2, 32'h0010_0004);
        pins[20] = 1'b1; wait_n(3);
        rd(1, 32'h0010_0000, "R8 recorded while disabled");
        chk("R9 masked", {30'b0, irq}, 32'h0);
        wr(0, 32'h0010_0000); #1;
        chk("R9 high group", {30'b0, irq}, 32'h2);
        pins[2] = 1'b1; wait_n(3);
        wr(0, 32'h0010_0004); #1;
        chk("R9 both groups", {30'b0, irq}, 32'h3);
        wr(1, 32'h0010_0000); #1;
        chk("R9 low group only", {30'b0, irq}, 32'h1);

        // R10 wakeup
        wr(5, 32'h4); #1;
        chk("R10 wake on", {31'b0, wake}, 32'h1);
        wr(0, 32'h0); #1;
        chk("R10 wake independent of ien", {31'b0, wake}, 32'h1);
        chk("R9 disabled again", {30'b0, irq}, 32'h0);
        wr(1, 32'h4); #1;
        chk("R10 wake off after clear", {31'b0, wake}, 32'h0);

        wait_n(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule